// File: doc/BRIEF.md
# DMA Channel Interrupt and Control Registers

This block holds the software-visible control state of one DMA channel. Five event pulses from the channel's transfer engine are captured into sticky status bits: fragment done, block done, transaction done, list done and configuration error. Each status bit has an enable bit that lets it reach the channel interrupt line. Software clears a status bit by writing a one to a matching clear bit. The clear bits act only as write pulses and hold no state.

The same register bus also reaches three more controls. The configuration word holds the channel enable and a skip-wait-for-block-done option. A request word issues a one-cycle software start pulse. A pause word carries a pause request to the engine and reports back whether the engine has actually stopped.

Access is by full 32-bit words. A read strobe returns data on `bus_rdata` after the next clock edge. Register byte offsets: interrupt word 0x00, configuration 0x04, request 0x08, pause 0x0C. All other offsets read as zero.

Top module: `dmach_regs`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `sw_req`, `chan_en`, `wait_bdone_skip` and `pause_req` are low.
- R2: In the interrupt word, bits 4:0 are read/write enables, in this order from bit 0: fragment, block, transaction, list, configuration error.
- R3: A high `evt_in[i]` in a clock cycle sets status bit 16+i of the interrupt word at that edge, whether or not its enable is set. The bit stays set until it is cleared.
- R4: Writing the interrupt word with bit 24+i set clears status bit 16+i. Clear bits written as zero leave their status bits alone. Data written to bits 20:16 has no effect.
- R5: When an event and a clear for the same bit fall in the same cycle, the event wins and the status bit ends up set.
- R6: Bits 28:24 of the interrupt word always read as zero.
- R7: `irq` is high exactly when some status bit and its enable are both set. It follows the state at the same clock edge at which the status or enable changes.
- R8: In the configuration word, bit 0 is the channel enable, driven on `chan_en`. Bit 24 is the skip-wait-for-block-done option, driven on `wait_bdone_skip`. All other bits read as zero.
- R9: Writing the request word with bit 0 set makes `sw_req` high for exactly the one cycle after that write edge. Writing zero in bit 0 gives no pulse. The request word reads as zero.
- R10: In the pause word, bit 0 is a read/write pause request, driven on `pause_req`. Bit 2 is read-only and shows `engine_paused` as sampled at the previous edge. Writes to bit 2 are ignored.
- R11: Read data is registered: it appears on `bus_rdata` after the edge that samples the read strobe, and it holds until the next read. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_in | input | 5 | Event pulses from the transfer engine |
| engine_paused | input | 1 | Engine reports it has stopped |
| chan_en | output | 1 | Channel enable |
| wait_bdone_skip | output | 1 | Skip wait for block done |
| sw_req | output | 1 | One-cycle software start request |
| pause_req | output | 1 | Pause request to the engine |
| irq | output | 1 | Channel interrupt |

## Verification
The bench drives an event and a clear for the same bit in the same cycle. A design that gives the clear priority would lose the event and leave the interrupt low. It writes ones into the status and paused-status fields to catch a design that lets software forge status. It reads the clear bits back to catch a design that stores them. Random mixes of events, enable writes and clears check `irq` in the cycle after each edge, which exposes an interrupt that lags one cycle behind or ignores the enable mask.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int DATA_W        = 32;
  localparam int ENA_LSB       = 0;
  localparam int STS_LSB       = 16;
  localparam int CLR_LSB       = 24;
  localparam int CFG_EN_BIT    = 0;
  localparam int CFG_WAIT_BIT  = 24;
  localparam int REQ_BIT       = 0;
  localparam int PAUSE_REQ_BIT = 0;
  localparam int PAUSE_STS_BIT = 2;
  // word indices (byte offset / 4)
  localparam int IDX_INT   = 0;
  localparam int IDX_CFG   = 1;
  localparam int IDX_REQ   = 2;
  localparam int IDX_PAUSE = 3;
endpackage

// File: rtl/dmach_int_status.sv
module dmach_int_status #(
  parameter int EVT_N = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_N-1:0] evt,
  input  logic             en_wr,
  input  logic [EVT_N-1:0] en_wdata,
  input  logic [EVT_N-1:0] clr,
  output logic [EVT_N-1:0] en_q,
  output logic [EVT_N-1:0] sts_q,
  output logic             irq
);
  logic [EVT_N-1:0] sts_next;
  logic [EVT_N-1:0] en_next;

  genvar i;
  generate
    for (i = 0; i < EVT_N; i++) begin : g_bit
      // event has priority over clear
      assign sts_next[i] = evt[i] ? 1'b1 : (clr[i] ? 1'b0 : sts_q[i]);
      always_ff @(posedge clk) begin
        if (rst) sts_q[i] <= 1'b0;
        else     sts_q[i] <= sts_next[i];
      end
    end
  endgenerate

  assign en_next = en_wr ? en_wdata : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      irq  <= 1'b0;
    end else begin
      en_q <= en_next;
      irq  <= |(sts_next & en_next);
    end
  end

  assert_evt_sets_R3: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((sts_q & $past(evt)) == $past(evt)));
  assert_evt_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ((evt & clr) != '0) |=> ((sts_q & $past(evt & clr)) == $past(evt & clr)));
  assert_clr_R4: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~evt) != '0) |=> ((sts_q & $past(clr & ~evt)) == '0));
  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (|(sts_q & en_q)));
endmodule

// File: rtl/dmach_ctl_regs.sv
module dmach_ctl_regs (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_en_d,
  input  logic cfg_wait_d,
  input  logic req_set,
  input  logic pause_wr,
  input  logic pause_d,
  input  logic engine_paused,
  output logic chan_en,
  output logic wait_opt,
  output logic sw_req,
  output logic pause_req,
  output logic paused
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en   <= 1'b0;
      wait_opt  <= 1'b0;
      sw_req    <= 1'b0;
      pause_req <= 1'b0;
      paused    <= 1'b0;
    end else begin
      if (cfg_wr) begin
        chan_en  <= cfg_en_d;
        wait_opt <= cfg_wait_d;
      end
      sw_req <= req_set;
      if (pause_wr) pause_req <= pause_d;
      paused <= engine_paused;
    end
  end

  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    sw_req |=> !sw_req || $past(req_set));
  assert_req_src_R9: assert property (@(posedge clk) disable iff (rst)
    req_set |=> sw_req);
  assert_pause_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !pause_wr |=> $stable(pause_req));
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs #(
  parameter int EVT_N  = 5,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [EVT_N-1:0]  evt_in,
  input  logic              engine_paused,
  output logic              chan_en,
  output logic              wait_bdone_skip,
  output logic              sw_req,
  output logic              pause_req,
  output logic              irq
);
  import dmach_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_en, rd_en;
  logic             int_wr, cfg_wr, req_wr, pause_wr;
  logic [EVT_N-1:0] en_q, sts_q, clr;
  logic             paused;
  logic [31:0]      rd_word;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign int_wr   = wr_en && (int'(idx) == IDX_INT);
  assign cfg_wr   = wr_en && (int'(idx) == IDX_CFG);
  assign req_wr   = wr_en && (int'(idx) == IDX_REQ);
  assign pause_wr = wr_en && (int'(idx) == IDX_PAUSE);
  assign clr      = int_wr ? bus_wdata[CLR_LSB +: EVT_N] : '0;

  dmach_int_status #(.EVT_N(EVT_N)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt_in),
    .en_wr    (int_wr),
    .en_wdata (bus_wdata[ENA_LSB +: EVT_N]),
    .clr      (clr),
    .en_q     (en_q),
    .sts_q    (sts_q),
    .irq      (irq)
  );

  dmach_ctl_regs u_ctl (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_en_d      (bus_wdata[CFG_EN_BIT]),
    .cfg_wait_d    (bus_wdata[CFG_WAIT_BIT]),
    .req_set       (req_wr && bus_wdata[REQ_BIT]),
    .pause_wr      (pause_wr),
    .pause_d       (bus_wdata[PAUSE_REQ_BIT]),
    .engine_paused (engine_paused),
    .chan_en       (chan_en),
    .wait_opt      (wait_bdone_skip),
    .sw_req        (sw_req),
    .pause_req     (pause_req),
    .paused        (paused)
  );

  always_comb begin
    rd_word = '0;
    case (int'(idx))
      IDX_INT: begin
        rd_word[ENA_LSB +: EVT_N] = en_q;
        rd_word[STS_LSB +: EVT_N] = sts_q;
      end
      IDX_CFG: begin
        rd_word[CFG_EN_BIT]   = chan_en;
        rd_word[CFG_WAIT_BIT] = wait_bdone_skip;
      end
      IDX_PAUSE: begin
        rd_word[PAUSE_REQ_BIT] = pause_req;
        rd_word[PAUSE_STS_BIT] = paused;
      end
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_word;
  end

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(idx) > IDX_PAUSE) |=> (bus_rdata == '0));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(bus_rdata));
  assert_clr_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && int'(idx) == IDX_INT) |=> (bus_rdata[CLR_LSB +: EVT_N] == '0));
endmodule

// File: tb/test_dmach_regs.sv
`timescale 1ns/1ps
module test_dmach_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  evt_in = '0;
  logic        engine_paused = 1'b0;
  logic        chan_en, wait_bdone_skip, sw_req, pause_req, irq;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [4:0] m_en = '0, m_sts = '0;

  always #2.5 clk = ~clk;

  dmach_regs i_dmach_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .engine_paused(engine_paused), .chan_en(chan_en),
    .wait_bdone_skip(wait_bdone_skip), .sw_req(sw_req),
    .pause_req(pause_req), .irq(irq)
  );

  function automatic logic [31:0] exp_int_word();
    return {11'b0, m_sts, 11'b0, m_en};
  endfunction

  function automatic logic exp_irq();
    return |(m_sts & m_en);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle (optional) together with an event pattern, ends at negedge after the edge
  task automatic cyc(logic sel, logic wr, logic [4:0] addr, logic [31:0] d, logic [4:0] ev);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = d; evt_in = ev;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; evt_in = '0;
    // bench model of the interrupt word (event beats clear)
    if (sel && wr && addr == 5'h00) begin
      m_sts = (m_sts & ~d[28:24]) | ev;
      m_en  = d[4:0];
    end else begin
      m_sts = m_sts | ev;
    end
  endtask

  task automatic rd(logic [4:0] addr, output logic [31:0] v);
    cyc(1, 0, addr, '0, '0);
    v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 sw_req", sw_req, 0);
    chk("R1 outs", {chan_en, wait_bdone_skip, pause_req}, 0);
    rd(5'h00, v); chk("R1 int", v, 0);
    rd(5'h04, v); chk("R1 cfg", v, 0);
    rd(5'h0C, v); chk("R1 pause", v, 0);

    // R2 enables
    cyc(1, 1, 5'h00, 32'h0000_0015, '0);
    rd(5'h00, v); chk("R2 en", v, exp_int_word());
    // R3 events latch regardless of enable; R7 masked
    cyc(0, 0, '0, '0, 5'h0A);
    rd(5'h00, v); chk("R3 sts", v, 32'h000A_0015);
    chk("R7 masked irq", irq, 0);
    // R4 status bits not writable; R7 irq at same edge
    cyc(1, 1, 5'h00, 32'h001F_0002, '0);
    chk("R7 irq on enable", irq, 1);
    rd(5'h00, v); chk("R4 sts unwritable", v, 32'h000A_0002);
    // R4 clear block status
    cyc(1, 1, 5'h00, 32'h0200_0002, '0);
    chk("R4 irq after clear", irq, 0);
    rd(5'h00, v); chk("R4 clear", v, 32'h0008_0002);
    // R5 event and clear same cycle on list bit, plus event on fragment
    cyc(1, 1, 5'h00, 32'h0800_0008, 5'h09);
    chk("R5 irq", irq, 1);
    rd(5'h00, v); chk("R5 event wins", v, 32'h0009_0008);
    // R6 clear bits read zero
    cyc(1, 1, 5'h00, 32'h1F00_001F, '0);
    rd(5'h00, v); chk("R6 clr readback", v, 32'h0000_001F);

    // R8 config
    cyc(1, 1, 5'h04, 32'hFFFF_FFFF, '0);
    chk("R8 outs", {chan_en, wait_bdone_skip}, 2'b11);
    rd(5'h04, v); chk("R8 cfg", v, 32'h0100_0001);
    cyc(1, 1, 5'h04, 32'h0100_0000, '0);
    chk("R8 outs2", {chan_en, wait_bdone_skip}, 2'b01);

    // R9 software request
    cyc(1, 1, 5'h08, 32'h0000_0001, '0);
    chk("R9 pulse", sw_req, 1);
    @(negedge clk); chk("R9 one cycle", sw_req, 0);
    cyc(1, 1, 5'h08, 32'hFFFF_FFFE, '0);
    chk("R9 no pulse", sw_req, 0);
    rd(5'h08, v); chk("R9 reads zero", v, 0);

    // R10 pause
    cyc(1, 1, 5'h0C, 32'hFFFF_FFFF, '0);
    chk("R10 pause_req", pause_req, 1);
    rd(5'h0C, v); chk("R10 sts ro", v, 32'h1);
    engine_paused = 1;
    @(negedge clk);
    rd(5'h0C, v); chk("R10 paused", v, 32'h5);
    cyc(1, 1, 5'h0C, 32'h0, '0);
    rd(5'h0C, v); chk("R10 release", v, 32'h4);
    chk("R10 pause_req low", pause_req, 0);

    // R11 unmapped and hold
    rd(5'h14, v); chk("R11 unmapped", v, 0);
    rd(5'h04, v);
    cyc(1, 1, 5'h04, 32'h0, '0);
    chk("R11 hold", bus_rdata, 32'h0100_0000);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [31:0] d;
      logic [4:0] ev;
      op = $urandom % 4;
      d  = $urandom;
      ev = ($urandom % 3 == 0) ? 5'($urandom) : 5'h0;
      case (op)
        0: cyc(0, 0, '0, '0, ev);
        1: cyc(1, 1, 5'h00, d, '0);
        2: cyc(1, 1, 5'h00, d, ev);
        default: begin
          rd(5'h00, v);
          chk("R3 random int word", v, exp_int_word());
        end
      endcase
      chk("R7 random irq", irq, exp_irq());
    end
    finish_run();
  end
endmodule